// File: doc/BRIEF.md
# LED Blink Generator with Autostop

This block drives a single LED with a programmable blink pattern. A free-running prescaler turns the system clock into ticks, with a spacing set by a 4-bit power-of-two exponent. A 12-bit period counter steps once per tick and wraps at the programmed period. The LED is lit while that counter is below a 12-bit duty value, so software sets both the blink rate and the on fraction.

When autostop is enabled, the block counts finished periods against a 16-bit limit. When the last period ends, it clears its own enable bit and darkens the LED. It also sets an interrupt flag, which reaches the interrupt pin unless the mask bit is set. Any register write clears the flag. Software programs the block through a simple write port with a combinational read port. Clock selection and gating are outside the block.

Top module: `led_blinker`

## Requirements
- R1: After reset all four registers read as zero, the LED is off and the interrupt output is low.
- R2: The register map is selected by a 2-bit address. Address 0 is control, 7 bits: bits 3:0 are the exponent, bit 4 is enable, bit 5 is autostop and bit 6 is the interrupt mask. Address 1 is the period (12 bits), address 2 the duty (12 bits) and address 3 the autostop count (16 bits). Reads return the stored value zero-extended to 16 bits.
- R3: With exponent n, a tick occurs every 2^(13-n) clocks, counted from the latest control write. n=13 ticks every clock and n=0 is the slowest.
- R4: The period counter restarts at 0 on a control write. It advances by one per tick and wraps to 0 after reaching period-1. A period of 0 acts as 1.
- R5: While enabled, the LED is on exactly when the period counter is below the duty value. A duty of 0 keeps it dark, and a duty at or above the period keeps it lit.
- R6: With the enable bit 0 the LED is off and the counters do not advance.
- R7: A control write, or a write to the count register, loads the remaining-period copy. With autostop set, each wrap decrements the copy. A wrap while the copy is 1 or 0 clears the enable bit (visible on readback), zeroes the period counter, darkens the LED and sets the interrupt flag.
- R8: The interrupt output is high only while the flag is set and the mask bit is 0.
- R9: Any register write clears the flag, unless an autostop ends in the same cycle. In that case the flag is set.
- R10: Exponent values 14 and 15 behave exactly like 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select for writes |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Register select for reads |
| rd_data | output | 16 | Read data, combinational |
| led | output | 1 | LED drive, high = lit |
| irq | output | 1 | Autostop interrupt |

## Verification
Directed runs cover these cases:
- duty 0, duty below the period and duty above the period, which separate the three LED shapes;
- exponents 13, 12 and 15, which separate tick spacing from clamping;
- masked and unmasked autostop runs, with a write that follows, which separate flag setting, masking and clearing.

Random runs then mix exponents from 10 to 15, small periods, duties and counts, and writes at random moments, including writes that land on a wrap. These compare the LED and interrupt on every cycle with a reference model in the bench, and compare register reads.

// File: rtl/led_blinker.sv
module led_blinker #(
  parameter int EXP_MAX = 13,
  parameter int PW      = 12,
  parameter int CW      = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [15:0] rd_data,
  output logic        led,
  output logic        irq
);
  localparam logic [3:0] EXP_TOP = 4'(EXP_MAX);

  logic [6:0]         ctrl_q;
  logic [PW-1:0]      per_q, duty_q, pcnt_q;
  logic [CW-1:0]      cnt_q, left_q;
  logic [EXP_MAX-1:0] pre_q;
  logic               flag_q;

  wire en   = ctrl_q[4];
  wire auto = ctrl_q[5];
  wire msk  = ctrl_q[6];
  wire [3:0] exp_c = (ctrl_q[3:0] > EXP_TOP) ? EXP_TOP : ctrl_q[3:0];
  wire [EXP_MAX-1:0] div_mask = {EXP_MAX{1'b1}} >> exp_c;
  wire tick = en && ((pre_q & div_mask) == div_mask);
  wire [PW-1:0] per_eff = (per_q == '0) ? PW'(1) : per_q;
  wire wrap = tick && (({1'b0, pcnt_q} + 1'b1) >= {1'b0, per_eff});
  wire ctrl_wr = wr_en && (wr_addr == 2'd0);
  wire cnt_wr  = wr_en && (wr_addr == 2'd3);
  wire stop = wrap && auto && (left_q <= CW'(1)) && !ctrl_wr;

  assign led = en && (pcnt_q < duty_q);
  assign irq = flag_q && !msk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      per_q  <= '0;
      duty_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          2'd0: ctrl_q <= wr_data[6:0];
          2'd1: per_q  <= wr_data[PW-1:0];
          2'd2: duty_q <= wr_data[PW-1:0];
          default: cnt_q <= wr_data[CW-1:0];
        endcase
      end
      if (stop) ctrl_q[4] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q  <= '0;
      pcnt_q <= '0;
      left_q <= '0;
    end else begin
      if (ctrl_wr) pre_q <= '0;
      else if (en) pre_q <= pre_q + 1'b1;

      if (ctrl_wr || stop) pcnt_q <= '0;
      else if (tick) pcnt_q <= wrap ? '0 : pcnt_q + 1'b1;

      if (ctrl_wr) left_q <= cnt_q;
      else if (cnt_wr) left_q <= wr_data[CW-1:0];
      else if (wrap && auto && !stop) left_q <= left_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else if (stop) flag_q <= 1'b1;
    else if (wr_en) flag_q <= 1'b0;
  end

  always_comb begin
    case (rd_addr)
      2'd0: rd_data = {9'b0, ctrl_q};
      2'd1: rd_data = 16'(per_q);
      2'd2: rd_data = 16'(duty_q);
      default: rd_data = 16'(cnt_q);
    endcase
  end
endmodule

// File: rtl/led_blinker_chk.sv
module led_blinker_chk #(
  parameter int PW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          led,
  input logic          stop,
  input logic          flag,
  input logic [PW-1:0] pcnt
);
  AST_STOP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !led); // R7
  AST_STOP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> flag); // R7
  AST_WRITE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !stop) |=> !flag); // R9
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !wr_en) |=> flag); // R9
  AST_PCNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pcnt != $past(pcnt)) |-> (pcnt == '0 || pcnt == PW'($past(pcnt) + 1'b1))); // R4
endmodule

bind led_blinker led_blinker_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .led(led),
  .stop(stop), .flag(flag_q), .pcnt(pcnt_q)
);

// File: tb/led_blinker_tb.sv
`timescale 1ns/1ps
module led_blinker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        led, irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  led_blinker u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .led(led), .irq(irq));

  always #2 clk = ~clk;

  // reference model
  logic [6:0]  m_ctrl;
  logic [11:0] m_per, m_duty, m_pcnt;
  logic [15:0] m_cnt, m_left;
  int          m_div;
  bit          m_flag;

  function automatic int clamp_exp(input logic [3:0] e);
    return (e > 4'd13) ? 13 : int'(e);
  endfunction

  function automatic logic [15:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return {9'b0, m_ctrl};
      2'd1: return {4'b0, m_per};
      2'd2: return {4'b0, m_duty};
      default: return m_cnt;
    endcase
  endfunction

  function automatic bit m_led();
    return m_ctrl[4] && (m_pcnt < m_duty);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = '0; m_per = '0; m_duty = '0; m_pcnt = '0;
      m_cnt = '0; m_left = '0; m_div = 0; m_flag = 0;
    end else begin
      bit e, tk, wp, cw, sw;
      int interval, pe;
      e = m_ctrl[4];
      interval = 1 << (13 - clamp_exp(m_ctrl[3:0]));
      tk = e && (m_div == interval - 1);
      pe = (m_per == 0) ? 1 : int'(m_per);
      wp = tk && (int'(m_pcnt) + 1 >= pe);
      cw = wr_en && wr_addr == 2'd0;
      sw = wp && m_ctrl[5] && (m_left <= 1) && !cw;
      if (cw) begin
        m_div = 0; m_pcnt = '0; m_left = m_cnt;
      end else begin
        if (e) m_div = tk ? 0 : m_div + 1;
        if (tk) m_pcnt = wp ? 12'd0 : m_pcnt + 12'd1;
        if (wr_en && wr_addr == 2'd3) m_left = wr_data;
        else if (wp && m_ctrl[5] && !sw) m_left = m_left - 16'd1;
      end
      if (sw) begin
        m_ctrl[4] = 1'b0; m_pcnt = '0; m_flag = 1;
      end else if (wr_en) m_flag = 0;
      if (wr_en) begin
        case (wr_addr)
          2'd0: m_ctrl = wr_data[6:0];
          2'd1: m_per = wr_data[11:0];
          2'd2: m_duty = wr_data[11:0];
          default: m_cnt = wr_data;
        endcase
      end
    end
  end

  // per-cycle comparison of outputs against the model (R3 R4 R5 R6 R7 R8 R10)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      total++;
      if (led !== m_led()) begin
        bad++;
        $display("FAIL R5 led at %0t: actual=%b expected=%b", $time, led, m_led());
      end
      total++;
      if (irq !== (m_flag && !m_ctrl[6])) begin
        bad++;
        $display("FAIL R8 irq at %0t: actual=%b expected=%b", $time, irq, m_flag && !m_ctrl[6]);
      end
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #400000;
    $display("FAIL watchdog expired");
    total++; bad++;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd7));
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    check("R1 led", {15'b0, led}, 16'h0);
    check("R1 irq", {15'b0, irq}, 16'h0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); check("R1 reg", v, 16'h0);
    end
    // R2 readback width
    wr(2'd1, 16'hF004); rd(2'd1, v); check("R2 period", v, 16'h0004);
    wr(2'd2, 16'h0002);
    wr(2'd3, 16'h0003); rd(2'd3, v); check("R2 count", v, 16'h0003);
    // autostop unmasked: exp 13, enable, autostop
    wr(2'd0, 16'hFF3D);
    rd(2'd0, v); check("R2 ctrl", v, 16'h003D);
    check("R5 lit at start", {15'b0, led}, 16'h1);
    cyc(1); check("R5 lit count1", {15'b0, led}, 16'h1);
    cyc(1); check("R5 dark count2", {15'b0, led}, 16'h0);
    cyc(15);
    check("R8 irq after stop", {15'b0, irq}, 16'h1);
    check("R6 led after stop", {15'b0, led}, 16'h0);
    rd(2'd0, v); check("R7 enable cleared", v, 16'h002D);
    wr(2'd1, 16'h0004);
    check("R9 write clears", {15'b0, irq}, 16'h0);
    // masked autostop
    wr(2'd0, 16'h007D);
    cyc(16);
    check("R8 masked irq", {15'b0, irq}, 16'h0);
    rd(2'd0, v); check("R7 masked stop", v, 16'h006D);
    // duty at/above period keeps LED lit
    wr(2'd2, 16'h0005);
    wr(2'd0, 16'h001D);
    for (int i = 0; i < 8; i++) begin
      check("R5 full duty", {15'b0, led}, 16'h1); cyc(1);
    end
    wr(2'd2, 16'h0000);
    for (int i = 0; i < 8; i++) begin
      check("R5 zero duty", {15'b0, led}, 16'h0); cyc(1);
    end
    // R10 clamp: exp 15, period 2, duty 1
    wr(2'd1, 16'h0002); wr(2'd2, 16'h0001);
    wr(2'd0, 16'h001F);
    check("R10 clamp c0", {15'b0, led}, 16'h1); cyc(1);
    check("R10 clamp c1", {15'b0, led}, 16'h0); cyc(1);
    check("R10 clamp c2", {15'b0, led}, 16'h1);
    // R3 exp 12 ticks every 2 clocks
    wr(2'd0, 16'h001C);
    check("R3 c0", {15'b0, led}, 16'h1); cyc(1);
    check("R3 c1", {15'b0, led}, 16'h1); cyc(1);
    check("R3 c2", {15'b0, led}, 16'h0); cyc(1);
    check("R3 c3", {15'b0, led}, 16'h0); cyc(1);
    check("R3 c4", {15'b0, led}, 16'h1);
    // R6 disabled: no progress
    wr(2'd0, 16'h000D);
    cyc(5); check("R6 disabled dark", {15'b0, led}, 16'h0);
    // random phase
    for (int it = 0; it < 2500; it++) begin
      logic [1:0] a;
      logic [15:0] d;
      cyc($urandom_range(0, 20));
      a = 2'($urandom_range(0, 3));
      case (a)
        2'd0: d = {9'b0, ($urandom_range(0, 3) == 0), 1'($urandom),
                   ($urandom_range(0, 5) != 0), 4'($urandom_range(10, 15))};
        2'd1: d = 16'($urandom_range(0, 7));
        2'd2: d = 16'($urandom_range(0, 8));
        default: d = 16'($urandom_range(0, 5));
      endcase
      wr(a, d);
      if ($urandom_range(0, 3) == 0) begin
        logic [1:0] ra;
        ra = 2'($urandom_range(0, 3));
        rd(ra, v); check("R2 random read", v, m_read(ra));
      end
    end
    cyc(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule